// File: doc/BRIEF.md
# Forwarding Operand Queue

This block is a small per-lane queue that feeds operands to one functional-unit input. The lane's requester names the operand it needs by a combined register and element-group address. The queue takes each accepted request into the next free slot, and that slot can be filled from either of two places. The first is a register-file read response, which finds its slot by a tag the queue hands out. The second is a result that one of five execution units is producing in that cycle. A forwarded result fills the slot at once, so the consumer does not wait for write-back and a second read.

The five forward ports are numbered 0 to 4: load, arithmetic, multiply/floating-point, mask and slide. Each forward carries a sequence stamp, and a larger stamp marks a younger producer. A slot that is still waiting for its register-file read also watches the forward ports, and the first match fills it. When the late read response then arrives, the queue drops it. Operands always leave in request order. Issue readiness treats a slot whose entry leaves in the current cycle as free.

Top module: `fwd_operand_queue`

## Requirements
- R1: After reset the queue is empty: out_valid is 0, req_ready is 1 and rf_rd_valid is 0.
- R2: A request accepted with no matching forward port raises rf_rd_valid in the same cycle, with rf_rd_addr equal to the request address and rf_rd_tag equal to {wrap bit, slot index}. The tag counts accepted requests modulo 2*DEPTH. A later response carrying that tag fills the entry with rf_rsp_data.
- R3: A request whose address equals the address of a valid forward port in the same cycle is stored with the forwarded data, and rf_rd_valid stays 0 for it.
- R4: A stored entry still waiting for its read is filled by a forward port that matches its address in a later cycle. A register-file response for that entry that arrives afterwards is discarded.
- R5: When several forward ports match, the port with the largest unsigned fwd_seq wins. On equal stamps the lower port index wins (0 load, 1 arithmetic, 2 multiply/FP, 3 mask, 4 slide).
- R6: Entries leave strictly in request order. out_valid is 1 only when the oldest entry is filled, and younger filled entries wait behind it.
- R7: With DEPTH entries held, req_ready is 0 unless the head entry leaves in that same cycle. If it does, req_ready is 1 and the new request is accepted.
- R8: A register-file response whose tag does not equal the tag of a waiting entry in the addressed slot changes nothing.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_addr | input | ADDR_W | Register and element-group address of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| rf_rd_valid | output | 1 | Register-file read to be issued |
| rf_rd_addr | output | ADDR_W | Address of that read |
| rf_rd_tag | output | log2(DEPTH)+1 | Tag the read response must carry |
| fwd_valid | input | 5 | Per-port forward valid (0 load, 1 arith, 2 mul/FP, 3 mask, 4 slide) |
| fwd_addr | input | 5*ADDR_W | Per-port result address, port p at bits p*ADDR_W |
| fwd_data | input | 5*DATA_W | Per-port result data |
| fwd_seq | input | 5*SEQ_W | Per-port producer age stamp, larger is younger |
| rf_rsp_valid | input | 1 | Register-file response present |
| rf_rsp_tag | input | log2(DEPTH)+1 | Tag of the response |
| rf_rsp_data | input | DATA_W | Response data |
| out_valid | output | 1 | Head operand ready for the functional unit |
| out_data | output | DATA_W | Head operand |
| out_ready | input | 1 | Functional unit takes the head operand |

## Verification
The bench drives all 31 non-empty sets of matching forward ports, using stamp patterns that produce both strict winners and ties. A design that picked ports by index alone, or that broke ties the wrong way, would deliver the wrong word. The bench also answers reads out of order and sends a stale-wrap tag. A queue that released a younger entry early or accepted the stale tag would show the wrong head or a spurious out_valid. Last, the bench forwards into an entry that is still waiting and then sends its late read response; a design that let the response overwrite the forwarded value would hand out old data. A request is also offered at full depth, both with and without a same-cycle pop, which catches a ready signal that ignores the leaving entry.

// File: rtl/fwd_operand_queue.sv
module fwd_operand_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEQ_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      rf_rd_valid,
  output logic [ADDR_W-1:0]         rf_rd_addr,
  output logic [$clog2(DEPTH):0]    rf_rd_tag,
  input  logic [4:0]                fwd_valid,
  input  logic [5*ADDR_W-1:0]       fwd_addr,
  input  logic [5*DATA_W-1:0]       fwd_data,
  input  logic [5*SEQ_W-1:0]        fwd_seq,
  input  logic                      rf_rsp_valid,
  input  logic [$clog2(DEPTH):0]    rf_rsp_tag,
  input  logic [DATA_W-1:0]         rf_rsp_data,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  input  logic                      out_ready
);
  localparam int NF = 5;
  localparam int PW = $clog2(DEPTH);
  localparam int TW = PW + 1;

  function automatic logic [DATA_W:0] pick(
    input logic [ADDR_W-1:0]      a,
    input logic [NF-1:0]          v,
    input logic [NF*ADDR_W-1:0]   fa,
    input logic [NF*DATA_W-1:0]   fd,
    input logic [NF*SEQ_W-1:0]    fs
  );
    logic              hit;
    logic [SEQ_W-1:0]  best;
    logic [DATA_W-1:0] d;
    hit  = 1'b0;
    best = '0;
    d    = '0;
    for (int p = 0; p < NF; p++) begin
      if (v[p] && fa[p*ADDR_W +: ADDR_W] == a &&
          (!hit || fs[p*SEQ_W +: SEQ_W] > best)) begin
        hit  = 1'b1;
        best = fs[p*SEQ_W +: SEQ_W];
        d    = fd[p*DATA_W +: DATA_W];
      end
    end
    return {hit, d};
  endfunction

  logic [TW-1:0]     wp, rp;
  logic [DEPTH-1:0]  occ, fil;
  logic [ADDR_W-1:0] adr [DEPTH];
  logic [DATA_W-1:0] dat [DEPTH];
  logic [TW-1:0]     tg  [DEPTH];
  logic [DATA_W:0]   ent_pick [DEPTH];
  logic [DATA_W:0]   req_pick;

  wire [TW-1:0] cnt = wp - rp;
  wire [PW-1:0] wi  = wp[PW-1:0];
  wire [PW-1:0] ri  = rp[PW-1:0];
  wire [PW-1:0] si  = rf_rsp_tag[PW-1:0];

  assign req_pick = pick(req_addr, fwd_valid, fwd_addr, fwd_data, fwd_seq);

  for (genvar g = 0; g < DEPTH; g++) begin : g_snoop
    assign ent_pick[g] = pick(adr[g], fwd_valid, fwd_addr, fwd_data, fwd_seq);
  end

  assign out_valid   = occ[ri] && fil[ri];
  assign out_data    = dat[ri];
  wire   pop         = out_valid && out_ready;
  assign req_ready   = (cnt != TW'(DEPTH)) || pop;
  wire   push        = req_valid && req_ready;
  assign rf_rd_valid = push && !req_pick[DATA_W];
  assign rf_rd_addr  = req_addr;
  assign rf_rd_tag   = wp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
      fil <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        adr[i] <= '0;
        dat[i] <= '0;
        tg[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (occ[i] && !fil[i]) begin
          if (ent_pick[i][DATA_W]) begin
            fil[i] <= 1'b1;
            dat[i] <= ent_pick[i][DATA_W-1:0];
          end else if (rf_rsp_valid && si == PW'(i) && rf_rsp_tag == tg[i]) begin
            fil[i] <= 1'b1;
            dat[i] <= rf_rsp_data;
          end
        end
      end
      if (pop) begin
        occ[ri] <= 1'b0;
        fil[ri] <= 1'b0;
        rp      <= rp + 1'b1;
      end
      if (push) begin
        occ[wi] <= 1'b1;
        fil[wi] <= req_pick[DATA_W];
        dat[wi] <= req_pick[DATA_W-1:0];
        adr[wi] <= req_addr;
        tg[wi]  <= wp;
        wp      <= wp + 1'b1;
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TW'(DEPTH));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TW'(DEPTH) && !pop) |=> (cnt == TW'(DEPTH)));

  // R9
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  rd_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_valid && !pop) |=> (cnt == $past(cnt) + 1'b1));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid);
endmodule

// File: tb/tb_fwd_operand_queue.sv
`timescale 1ns/1ps
module tb_fwd_operand_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_addr;
  logic        req_ready;
  logic        rf_rd_valid;
  logic [7:0]  rf_rd_addr;
  logic [2:0]  rf_rd_tag;
  logic [4:0]  fwd_valid;
  logic [39:0] fwd_addr;
  logic [159:0] fwd_data;
  logic [19:0] fwd_seq;
  logic        rf_rsp_valid;
  logic [2:0]  rf_rsp_tag;
  logic [31:0] rf_rsp_data;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready;

  int errors = 0;
  int checks = 0;
  int pc = 0;

  always #2 clk = ~clk;

  fwd_operand_queue dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rf_rd_valid(rf_rd_valid), .rf_rd_addr(rf_rd_addr),
    .rf_rd_tag(rf_rd_tag), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .fwd_seq(fwd_seq), .rf_rsp_valid(rf_rsp_valid),
    .rf_rsp_tag(rf_rsp_tag), .rf_rsp_data(rf_rsp_data), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_fwd(input int p, input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    fwd_valid[p] = 1'b1;
    fwd_addr[p*8 +: 8]   = a;
    fwd_data[p*32 +: 32] = d;
    fwd_seq[p*4 +: 4]    = s;
  endtask

  task automatic push(input logic [7:0] a, input logic pop_too,
                      output logic acc, output logic rd, output logic [2:0] tg);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    out_ready = pop_too;
    #1;
    acc = req_ready;
    rd  = rf_rd_valid;
    tg  = rf_rd_tag;
    @(posedge clk);
    #1;
    if (acc) pc++;
    req_valid = 1'b0;
    out_ready = 1'b0;
    fwd_valid = '0;
  endtask

  task automatic pop(output logic v, output logic [31:0] d);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    v = out_valid;
    d = out_data;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  task automatic peek(output logic v, output logic [31:0] d);
    @(negedge clk);
    #1;
    v = out_valid;
    d = out_data;
  endtask

  task automatic respond(input logic [2:0] t, input logic [31:0] d);
    @(negedge clk);
    rf_rsp_valid = 1'b1;
    rf_rsp_tag   = t;
    rf_rsp_data  = d;
    @(posedge clk);
    #1;
    rf_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic acc, rd, v;
    logic [2:0] tg;
    logic [2:0] tags [4];
    logic [31:0] d;
    req_valid = 0; req_addr = 0; fwd_valid = 0; fwd_addr = 0; fwd_data = 0;
    fwd_seq = 0; rf_rsp_valid = 0; rf_rsp_tag = 0; rf_rsp_data = 0; out_ready = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    peek(v, d);
    chk(v == 0, "R1 out_valid", v, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(rf_rd_valid == 0, "R1 rf_rd_valid", rf_rd_valid, 0);

    // R3 / R5: every non-empty set of matching forward ports
    for (int m = 1; m < 32; m++) begin
      int best;
      int s [5];
      best = -1;
      for (int p = 0; p < 5; p++) begin
        s[p] = (m * 7 + p * 3) % 4;
        set_fwd(p, m[p] ? 8'h40 : 8'h41, 32'(m * 16 + p), 4'(s[p]));
        if (m[p] && (best < 0 || s[p] > s[best])) best = p;
      end
      push(8'h40, 1'b0, acc, rd, tg);
      chk(acc == 1 && rd == 0, "R3 forwarded request skips read", rd, 0);
      pop(v, d);
      chk(v == 1 && d == 32'(m * 16 + best), "R5 forward winner", d, m * 16 + best);
    end

    // R2 / R7 / R6: fill with reads, answer out of order
    for (int k = 0; k < 4; k++) begin
      int et;
      et = pc % 8;
      push(8'(10 + k), 1'b0, acc, rd, tg);
      chk(acc && rd && tg == 3'(et), "R2 read issued with tag", tg, et);
      tags[k] = tg;
    end
    push(8'd14, 1'b0, acc, rd, tg);
    chk(acc == 0, "R7 full without pop refuses", acc, 0);
    respond(tags[2], 32'd1002);
    peek(v, d);
    chk(v == 0, "R6 younger filled entry waits", v, 0);
    respond(tags[0], 32'd1000);
    respond(tags[1], 32'd1001);
    respond(tags[3], 32'd1003);
    for (int k = 0; k < 4; k++) begin
      pop(v, d);
      chk(v && d == 32'(1000 + k), "R6 request order", d, 1000 + k);
    end

    // R4: late forward into a waiting entry, then stale read response
    push(8'd20, 1'b0, acc, rd, tg);
    set_fwd(3, 8'd20, 32'd555, 4'd0);
    @(posedge clk);
    #1 fwd_valid = '0;
    respond(tg, 32'd777);
    pop(v, d);
    chk(v && d == 32'd555, "R4 forward fills pending, read discarded", d, 555);

    // R8: response with wrong wrap bit ignored
    push(8'd30, 1'b0, acc, rd, tg);
    respond(tg ^ 3'b100, 32'd888);
    peek(v, d);
    chk(v == 0, "R8 stale tag ignored", v, 0);
    respond(tg, 32'd999);
    pop(v, d);
    chk(v && d == 32'd999, "R2 read response fills", d, 999);

    // R7: full plus same-cycle pop accepts; R9 hold
    for (int k = 0; k < 4; k++) begin
      set_fwd(1, 8'(50 + k), 32'(2000 + k), 4'd0);
      push(8'(50 + k), 1'b0, acc, rd, tg);
    end
    for (int k = 0; k < 3; k++) begin
      peek(v, d);
      chk(v && d == 32'd2000, "R9 head held", d, 2000);
    end
    set_fwd(2, 8'd54, 32'd2004, 4'd0);
    push(8'd54, 1'b1, acc, rd, tg);
    chk(acc == 1, "R7 full with pop accepts", acc, 1);
    for (int k = 1; k < 5; k++) begin
      pop(v, d);
      chk(v && d == 32'(2000 + k), "R7 order after full pop", d, 2000 + k);
    end
    peek(v, d);
    chk(v == 0, "R6 empty after drain", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule